// File: doc/BRIEF.md
# Multi-Rate Divider Selection Sequencer

This block chooses the divider modulus and the oscillator curve for a clock-recovery loop that must lock to one of several serial data rates. In automatic mode it holds a 3-bit rate code and steps it once for every acquisition cycle that finishes without lock. The outside logic marks the end of each cycle with a one-clock pulse. The code stays put while the loop is locked. It also stays put while no input data is seen, so that reacquisition starts again at the rate that last worked.

In manual mode the code comes from an input and the modulus stays fixed. A standard-rate flag picks one of two decode tables. The result is a modulus of 1, 2, 4 or 8 and a low/high curve select. A manual code with no defined meaning gives a safe setting and raises a flag. The code is shown at the output, with its enable, only in automatic mode.

Top module: `rate_seq_top`

## Requirements
- R1: After reset the block is in automatic mode with code 000: `code_oe`=1, `code_out`=000, `div_mod`=4, `curve_low`=0, `code_bad`=0.
- R2: In automatic mode (`auto_sel`=1), a clock with `cycle_end`=1, `locked`=0 and `data_present`=1 advances the code by one, visible after that clock edge. On clocks without `cycle_end` the code holds.
- R3: In automatic mode the code wraps from 100 to 000 and never shows 101 to 111. On entering automatic mode from a manual code above 100, the code becomes 000 at the first clock.
- R4: While `locked`=1 the automatic code does not advance, even on `cycle_end`.
- R5: While `data_present`=0 the automatic code holds on `cycle_end`. When data returns, stepping resumes from that same code.
- R6: With `std_rate`=1 the codes decode as (`div_mod`, curve): 000→(4,high), 001→(2,low), 010→(2,high), 011→(1,low), 100→(1,high). In manual mode 101→(8,low) and 110→(8,high). `div_mod` carries the modulus as a binary number, and `curve_low`=1 means the low curve.
- R7: With `std_rate`=0 the curve is always high, and 000/001→4, 010/011→2, 100→1. In manual mode 101→1 and 110→8.
- R8: `curve_low` is 1 only when `std_rate`=1 and bit 0 of a valid code is 1.
- R9: In manual mode (`auto_sel`=0) `code_in` is registered on every clock and takes effect after that edge. `cycle_end`, `locked` and `data_present` have no effect in this mode.
- R10: Manual code 111 is invalid. It gives `div_mod`=1 on the high curve with `code_bad`=1. `code_bad` is 0 for every other code and mode.
- R11: `code_oe`=1 and `code_out` equals the code only in automatic mode. In manual mode `code_oe`=0 and `code_out`=000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_sel | input | 1 | 1 = automatic stepping, 0 = manual code |
| std_rate | input | 1 | Selects the decode table |
| cycle_end | input | 1 | One-clock pulse at the end of an acquisition cycle |
| locked | input | 1 | Loop is phase locked |
| data_present | input | 1 | Input transitions are being seen |
| code_in | input | 3 | Manual rate code |
| code_out | output | 3 | Automatic rate code, zero in manual mode |
| code_oe | output | 1 | `code_out` is driven (automatic mode) |
| div_mod | output | 4 | Divider modulus: 1, 2, 4 or 8 |
| curve_low | output | 1 | 1 = low oscillator curve |
| code_bad | output | 1 | Manual code is invalid |

## Verification
The bench aims at the 100→000 wrap and at a switch into automatic mode while a manual code of 101 to 111 is held. A design that gets these wrong would show an out-of-range code, or index a non-existent rate. It pulses `cycle_end` together with `locked` or with missing data. A sequencer with a bad hold condition would move off the last good rate and lengthen reacquisition. It sweeps both decode tables over all eight manual codes, including the paired codes of the non-standard table and code 111. A table error would show up as a wrong modulus, the low curve appearing without the standard flag, or a missing invalid flag. Random mixes of all inputs then compare every output, every cycle, against a model in the bench.

// File: rtl/rate_seq_pkg.sv
package rate_seq_pkg;
  localparam int CODE_W    = 3;
  localparam int DIV_W     = 4;
  localparam int LAST_AUTO = 4;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             low;
    logic             bad;
  } rate_sel_t;

  // log2 of the modulus for a valid code; curve handled separately
  function automatic logic [1:0] div_exp(input logic [CODE_W-1:0] c, input logic std);
    logic [1:0] e;
    unique case (c)
      3'd0:    e = 2'd2;
      3'd1:    e = std ? 2'd1 : 2'd2;
      3'd2:    e = 2'd1;
      3'd3:    e = std ? 2'd0 : 2'd1;
      3'd5:    e = std ? 2'd3 : 2'd0;
      3'd6:    e = 2'd3;
      default: e = 2'd0;
    endcase
    return e;
  endfunction

  function automatic rate_sel_t decode(input logic [CODE_W-1:0] c, input logic std);
    rate_sel_t r;
    r.bad = (c == '1);
    r.div = DIV_W'(1) << div_exp(c, std);
    r.low = std & c[0] & ~r.bad;
    return r;
  endfunction
endpackage

// File: rtl/rate_seq_counter.sv
module rate_seq_counter
  import rate_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_sel,
  input  logic              cycle_end,
  input  logic              locked,
  input  logic              data_present,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] cur_code,
  output logic              mode_auto,
  output logic              step_evt,
  output logic              wrap_evt
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(LAST_AUTO);

  logic out_of_range;
  logic [CODE_W-1:0] nxt;

  assign out_of_range = cur_code > LAST;
  assign step_evt = auto_sel & ~out_of_range & cycle_end & ~locked & data_present;
  assign wrap_evt = step_evt & (cur_code == LAST);

  always_comb begin
    nxt = cur_code;
    if (!auto_sel)         nxt = code_in;
    else if (out_of_range) nxt = '0;
    else if (wrap_evt)     nxt = '0;
    else if (step_evt)     nxt = cur_code + CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code  <= '0;
      mode_auto <= 1'b1;
    end else begin
      cur_code  <= nxt;
      mode_auto <= auto_sel;
    end
  end
endmodule

// File: rtl/rate_seq_decode.sv
module rate_seq_decode
  import rate_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              std_rate,
  input  logic              mode_auto,
  output logic [DIV_W-1:0]  div_mod,
  output logic              curve_low,
  output logic              code_bad
);
  rate_sel_t sel;
  assign sel       = decode(code, std_rate);
  assign div_mod   = sel.div;
  assign curve_low = sel.low;
  assign code_bad  = sel.bad & ~mode_auto;
endmodule

// File: rtl/rate_seq_top.sv
module rate_seq_top
  import rate_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_sel,
  input  logic              std_rate,
  input  logic              cycle_end,
  input  logic              locked,
  input  logic              data_present,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              code_oe,
  output logic [DIV_W-1:0]  div_mod,
  output logic              curve_low,
  output logic              code_bad
);
  logic [CODE_W-1:0] cur_code;
  logic mode_auto, step_evt, wrap_evt;

  rate_seq_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .cycle_end(cycle_end),
    .locked(locked), .data_present(data_present), .code_in(code_in),
    .cur_code(cur_code), .mode_auto(mode_auto),
    .step_evt(step_evt), .wrap_evt(wrap_evt)
  );

  rate_seq_decode u_dec (
    .code(cur_code), .std_rate(std_rate), .mode_auto(mode_auto),
    .div_mod(div_mod), .curve_low(curve_low), .code_bad(code_bad)
  );

  assign code_oe  = mode_auto;
  assign code_out = mode_auto ? cur_code : '0;
endmodule

// File: rtl/rate_seq_chk.sv
module rate_seq_chk
  import rate_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              auto_sel,
  input logic              std_rate,
  input logic              cycle_end,
  input logic              locked,
  input logic              data_present,
  input logic [CODE_W-1:0] code_out,
  input logic              code_oe,
  input logic [DIV_W-1:0]  div_mod,
  input logic              curve_low,
  input logic              code_bad,
  input logic              wrap_evt
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(LAST_AUTO);

  assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    code_oe |-> code_out <= LAST);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> code_out == '0);

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && code_oe && cycle_end && !locked && data_present) |=>
      code_out == (($past(code_out) == LAST) ? '0 : $past(code_out) + CODE_W'(1)));

  assert_hold_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && code_oe && locked) |=> $stable(code_out));

  assert_hold_nodata_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && code_oe && !data_present) |=> $stable(code_out));

  assert_modulus_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_mod) == 1);

  assert_low_needs_std_R8: assert property (@(posedge clk) disable iff (!rst_n)
    curve_low |-> std_rate);

  assert_bad_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code_bad |-> (div_mod == DIV_W'(1) && !curve_low && !code_oe));

  assert_manual_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !code_oe |-> code_out == '0);
endmodule

bind rate_seq_top rate_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .std_rate(std_rate),
  .cycle_end(cycle_end), .locked(locked), .data_present(data_present),
  .code_out(code_out), .code_oe(code_oe), .div_mod(div_mod),
  .curve_low(curve_low), .code_bad(code_bad), .wrap_evt(wrap_evt)
);

// File: tb/rate_seq_top_tb.sv
module rate_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_sel = 1'b1, std_rate = 1'b1, cycle_end = 1'b0, locked = 1'b0, data_present = 1'b1;
  logic [2:0] code_in = 3'd0;
  logic [2:0] code_out;
  logic code_oe, curve_low, code_bad;
  logic [3:0] div_mod;

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_code = 3'd0;
  logic m_auto = 1'b1;

  always #4 clk = ~clk;

  rate_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .auto_sel(auto_sel), .std_rate(std_rate),
    .cycle_end(cycle_end), .locked(locked), .data_present(data_present),
    .code_in(code_in), .code_out(code_out), .code_oe(code_oe),
    .div_mod(div_mod), .curve_low(curve_low), .code_bad(code_bad)
  );

  // expected modulus: tables packed as nibbles, code 0 in the low nibble
  function automatic logic [3:0] exp_div(input logic [2:0] c, input logic s);
    logic [31:0] tbl;
    tbl = s ? 32'h1_8_8_1_1_2_2_4 : 32'h1_8_1_1_2_2_4_4;
    return tbl[c*4 +: 4];
  endfunction

  function automatic logic exp_low(input logic [2:0] c, input logic s);
    return s && (c == 3'd1 || c == 3'd3 || c == 3'd5);
  endfunction

  task automatic check(input string tag);
    logic [2:0] e_out;
    logic [3:0] e_div;
    logic e_low, e_bad;
    e_out = m_auto ? m_code : 3'd0;
    e_div = exp_div(m_code, std_rate);
    e_low = exp_low(m_code, std_rate);
    e_bad = !m_auto && m_code == 3'd7;
    n_chk++;
    if (code_out !== e_out || code_oe !== m_auto || div_mod !== e_div ||
        curve_low !== e_low || code_bad !== e_bad) begin
      n_fail++;
      $display("FAIL %s: got out=%0d oe=%0d div=%0d low=%0d bad=%0d exp out=%0d oe=%0d div=%0d low=%0d bad=%0d",
               tag, code_out, code_oe, div_mod, curve_low, code_bad,
               e_out, m_auto, e_div, e_low, e_bad);
    end
  endtask

  task automatic cyc(input logic a, input logic s, input logic ce, input logic lk,
                     input logic dp, input logic [2:0] ci, input string tag);
    auto_sel = a; std_rate = s; cycle_end = ce; locked = lk; data_present = dp; code_in = ci;
    @(posedge clk);
    if (!a) begin
      m_auto = 1'b0; m_code = ci;
    end else begin
      m_auto = 1'b1;
      if (m_code > 3'd4) m_code = 3'd0;
      else if (ce && !lk && dp) m_code = (m_code == 3'd4) ? 3'd0 : m_code + 3'd1;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2/R3: step all the way round, std table
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 0, 0, 1, 3'd0, "R2 idle hold");
      cyc(1, 1, 1, 0, 1, 3'd0, "R2 R3 R6 step");
    end
    // R7 on same walk with std=0
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 0, 1, 3'd0, "R7 R8 auto table");
    // R4 locked hold
    cyc(1, 1, 1, 0, 1, 3'd0, "R2 to code");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 1, 3'd0, "R4 locked hold");
    // R5 no data hold then resume
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, 3'd0, "R5 no data hold");
    cyc(1, 1, 1, 0, 1, 3'd0, "R5 resume");
    // R9/R10/R11 manual sweep, both tables, noisy control inputs
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++) begin
        cyc(0, s[0], 1, 0, 1, c[2:0], "R6 R7 R9 R10 R11 manual");
        cyc(0, s[0], 1, 1, 0, c[2:0], "R9 manual hold");
      end
    // R3 entering auto from out-of-range codes
    for (int c = 5; c < 8; c++) begin
      cyc(0, 1, 0, 0, 1, c[2:0], "R10 manual load");
      cyc(1, 1, 1, 0, 1, 3'd0, "R3 enter auto forced 000");
      cyc(1, 1, 1, 0, 1, 3'd0, "R3 R2 step after entry");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic a;
      a = ($urandom % 10) != 0;
      cyc(a, 1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) != 0,
          3'($urandom), "R2 R8 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule